// File: doc/BRIEF.md
# Flash Embedded Operation Status Generator

This block sits on the device side of a NOR flash model and produces the word that a host sees on the data bus while an embedded program or erase runs. It accepts single-cycle command strobes (program, sector erase, chip erase, suspend, resume, reset). It tracks the operation state, the set of sectors chosen for erase and three internal cycle counters. On every read it either passes the supplied array word through or returns a status word.

The status word carries two independent toggle bits. The operation toggle shows that an embedded operation is running. The sector toggle shows that the sector being read is selected for erase. Polling both gives mode and sector information together. The status word also carries a sticky timeout bit and an erase-begun bit. A program that would turn any 0 back into a 1 cannot finish. It stalls until the pulse limit runs out and then reports a timeout. Only a reset command leaves the failed state.

Top module: `flash_op_status`

## Requirements
- R1: With no operation running, and in erase suspend for reads of sectors not selected for erase, `rd_data` equals `array_data` in the same cycle.
- R2: A status word has bit 6 = operation toggle, bit 5 = timeout, bit 3 = erase begun and bit 2 = sector toggle. All other bits are 0. Both toggles are 0 after `rst`.
- R3: The operation toggle inverts after each status read during program, erase window, erase, suspended program and failed state. It stays unchanged during erase suspend and in cycles without a read.
- R4: The sector toggle inverts after a status read only if the read sector is selected for erase. Reads of other sectors leave it unchanged.
- R5: Command encoding on `cmd_op` is 0 program, 1 sector erase, 2 chip erase, 3 suspend, 4 resume, 5 reset. A program with no bit going from 0 to 1 (`~cmd_old_data & cmd_new_data` is zero) shows status for exactly PROG_CYCLES cycles after its command edge and then returns to array read.
- R6: A program with any bit going from 0 to 1 stays busy with timeout 0 for LIMIT cycles. It then reports timeout 1, and timeout stays 1 for as long as no reset command arrives.
- R7: A reset command in the failed state returns to array read, or to erase suspend if the failed program was issued during suspend. A reset command is ignored while an operation is running.
- R8: A sector erase opens a window of WIN_CYCLES cycles with erase-begun 0. Each further sector erase inside the window adds its sector and restarts the window. After the window the erase runs with erase-begun 1.
- R9: A chip erase selects every sector and starts at once with erase-begun 1 and no window.
- R10: An erase runs for ERASE_CYCLES active cycles. Suspend pauses the erase count, resume continues it, and completion clears the selected set.
- R11: A program issued during erase suspend runs like R5 and then returns to erase suspend with the selection kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code (see R5) |
| cmd_sector | input | SW | Target sector of a program or sector erase |
| cmd_old_data | input | DW | Word currently stored at the program target |
| cmd_new_data | input | DW | Word the program wants to store |
| rd_strobe | input | 1 | Read strobe, one cycle per read |
| rd_sector | input | SW | Sector addressed by the read |
| array_data | input | DW | Array word for the addressed location |
| rd_data | output | DW | Array word or status word for the current read |

## Verification
The hardest case to reach is a failed program issued during erase suspend. It needs a sector erase, the whole window, some erase progress, a suspend, a program that tries to raise a 0 and LIMIT stalled cycles. After that, a reset must bring the block back into suspend with the erase count intact. The stimulus counts every cycle of this chain, so the bench knows the exact cycle in which resume finishes the erase. Exact boundary reads are made at the window end, the program end and the timeout cycle, with back-to-back reads whose sector alternates between selected and unselected.

// File: rtl/fos_pkg.sv
package fos_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_EWIN  = 3'd2,
        ST_ERASE = 3'd3,
        ST_SUSP  = 3'd4,
        ST_SPROG = 3'd5,
        ST_FAIL  = 3'd6
    } fos_state_e;

    typedef enum logic [2:0] {
        CMD_PROG   = 3'd0,
        CMD_SERASE = 3'd1,
        CMD_CERASE = 3'd2,
        CMD_SUSP   = 3'd3,
        CMD_RESUME = 3'd4,
        CMD_RESET  = 3'd5
    } fos_cmd_e;

    // status word bit positions (host software decodes these)
    localparam int STAT_OPTOG  = 6;
    localparam int STAT_TMO    = 5;
    localparam int STAT_EBEGUN = 3;
    localparam int STAT_SECTOG = 2;

    // counter slots
    localparam int CTR_PROG  = 0;
    localparam int CTR_ERASE = 1;
    localparam int CTR_WIN   = 2;
    localparam int NCTR      = 3;

    typedef struct packed {
        logic op_tog;
        logic timeout;
        logic erase_begun;
        logic sec_tog;
    } fos_flags_t;

    function automatic logic is_busy(fos_state_e s);
        return (s == ST_PROG) || (s == ST_EWIN) || (s == ST_ERASE) ||
               (s == ST_SPROG) || (s == ST_FAIL);
    endfunction

    function automatic logic [7:0] pack_status(fos_flags_t f);
        logic [7:0] w;
        w = '0;
        w[STAT_OPTOG]  = f.op_tog;
        w[STAT_TMO]    = f.timeout;
        w[STAT_EBEGUN] = f.erase_begun;
        w[STAT_SECTOG] = f.sec_tog;
        return w;
    endfunction

endpackage

// File: rtl/fos_pulse_ctr.sv
module fos_pulse_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fos_seq.sv
module fos_seq
    import fos_pkg::*;
#(
    parameter int SECTORS      = 8,
    parameter int SW           = 3,
    parameter int CW           = 7,
    parameter int LIMIT        = 64,
    parameter int PROG_CYCLES  = 12,
    parameter int ERASE_CYCLES = 40,
    parameter int WIN_CYCLES   = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  fos_cmd_e           cmd,
    input  logic [SW-1:0]      cmd_sector,
    input  logic               prog_bad,
    input  logic [CW-1:0]      pcnt,
    input  logic [CW-1:0]      ecnt,
    input  logic [CW-1:0]      wcnt,
    output fos_state_e         st,
    output logic [SECTORS-1:0] sel_mask,
    output logic               erase_begun,
    output logic [NCTR-1:0]    ctr_clr,
    output logic [NCTR-1:0]    ctr_inc
);
    localparam logic [CW-1:0] P_LAST = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] E_LAST = CW'(ERASE_CYCLES - 1);
    localparam logic [CW-1:0] W_LAST = CW'(WIN_CYCLES - 1);
    localparam logic [CW-1:0] T_LAST = CW'(LIMIT - 1);

    fos_state_e         st_n;
    logic [SECTORS-1:0] mask_n;
    logic               eb_n;
    logic               bad_q, bad_n;
    logic               ret_susp_q, ret_susp_n;
    logic [SECTORS-1:0] sec_bit;

    always_comb sec_bit = SECTORS'(1) << cmd_sector;

    always_comb begin
        st_n       = st;
        mask_n     = sel_mask;
        eb_n       = erase_begun;
        bad_n      = bad_q;
        ret_susp_n = ret_susp_q;
        ctr_clr    = '0;
        ctr_inc    = '0;
        case (st)
            ST_IDLE: begin
                if (cmd_valid && cmd == CMD_PROG) begin
                    st_n = ST_PROG;
                    bad_n = prog_bad;
                    ctr_clr[CTR_PROG] = 1'b1;
                end else if (cmd_valid && cmd == CMD_SERASE) begin
                    st_n = ST_EWIN;
                    mask_n = sec_bit;
                    ctr_clr[CTR_WIN] = 1'b1;
                end else if (cmd_valid && cmd == CMD_CERASE) begin
                    st_n = ST_ERASE;
                    mask_n = '1;
                    eb_n = 1'b1;
                    ctr_clr[CTR_ERASE] = 1'b1;
                end
            end
            ST_PROG, ST_SPROG: begin
                if (!bad_q && pcnt == P_LAST) begin
                    st_n = (st == ST_SPROG) ? ST_SUSP : ST_IDLE;
                    ctr_clr[CTR_PROG] = 1'b1;
                end else if (pcnt == T_LAST) begin
                    st_n = ST_FAIL;
                    ret_susp_n = (st == ST_SPROG);
                end else begin
                    ctr_inc[CTR_PROG] = 1'b1;
                end
            end
            ST_EWIN: begin
                if (cmd_valid && cmd == CMD_SERASE) begin
                    mask_n = sel_mask | sec_bit;
                    ctr_clr[CTR_WIN] = 1'b1;
                end else if (wcnt == W_LAST) begin
                    st_n = ST_ERASE;
                    eb_n = 1'b1;
                    ctr_clr[CTR_WIN] = 1'b1;
                    ctr_clr[CTR_ERASE] = 1'b1;
                end else begin
                    ctr_inc[CTR_WIN] = 1'b1;
                end
            end
            ST_ERASE: begin
                if (ecnt == E_LAST) begin
                    st_n = ST_IDLE;
                    mask_n = '0;
                    eb_n = 1'b0;
                    ctr_clr[CTR_ERASE] = 1'b1;
                end else if (ecnt == T_LAST) begin
                    st_n = ST_FAIL;
                    ret_susp_n = 1'b0;
                end else if (cmd_valid && cmd == CMD_SUSP) begin
                    st_n = ST_SUSP;
                end else begin
                    ctr_inc[CTR_ERASE] = 1'b1;
                end
            end
            ST_SUSP: begin
                if (cmd_valid && cmd == CMD_PROG) begin
                    st_n = ST_SPROG;
                    bad_n = prog_bad;
                    ctr_clr[CTR_PROG] = 1'b1;
                end else if (cmd_valid && cmd == CMD_RESUME) begin
                    st_n = ST_ERASE;
                end
            end
            ST_FAIL: begin
                if (cmd_valid && cmd == CMD_RESET) begin
                    ctr_clr[CTR_PROG] = 1'b1;
                    if (ret_susp_q) begin
                        st_n = ST_SUSP;
                    end else begin
                        st_n = ST_IDLE;
                        mask_n = '0;
                        eb_n = 1'b0;
                        ctr_clr[CTR_ERASE] = 1'b1;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            sel_mask    <= '0;
            erase_begun <= 1'b0;
            bad_q       <= 1'b0;
            ret_susp_q  <= 1'b0;
        end else begin
            st          <= st_n;
            sel_mask    <= mask_n;
            erase_begun <= eb_n;
            bad_q       <= bad_n;
            ret_susp_q  <= ret_susp_n;
        end
    end
endmodule

// File: rtl/fos_toggles.sv
module fos_toggles (
    input  logic clk,
    input  logic rst,
    input  logic rd_strobe,
    input  logic status_rd,
    input  logic busy,
    input  logic selected,
    output logic op_tog,
    output logic sec_tog
);
    always_ff @(posedge clk) begin
        if (rst) begin
            op_tog  <= 1'b0;
            sec_tog <= 1'b0;
        end else if (rd_strobe && status_rd) begin
            if (busy)
                op_tog <= ~op_tog;
            if (selected)
                sec_tog <= ~sec_tog;
        end
    end
endmodule

// File: rtl/fos_rdmux.sv
module fos_rdmux
    import fos_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          status_rd,
    input  fos_flags_t    flags,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] status_w;

    always_comb begin
        status_w = DW'(pack_status(flags));
        rd_data  = status_rd ? status_w : array_data;
    end
endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
    import fos_pkg::*;
#(
    parameter int SECTORS      = 8,
    parameter int DW           = 8,
    parameter int LIMIT        = 64,
    parameter int PROG_CYCLES  = 12,
    parameter int ERASE_CYCLES = 40,
    parameter int WIN_CYCLES   = 10
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_valid,
    input  logic [2:0]                   cmd_op,
    input  logic [$clog2(SECTORS)-1:0]   cmd_sector,
    input  logic [DW-1:0]                cmd_old_data,
    input  logic [DW-1:0]                cmd_new_data,
    input  logic                         rd_strobe,
    input  logic [$clog2(SECTORS)-1:0]   rd_sector,
    input  logic [DW-1:0]                array_data,
    output logic [DW-1:0]                rd_data
);
    localparam int SW   = $clog2(SECTORS);
    localparam int MAXC = (LIMIT > WIN_CYCLES) ? LIMIT : WIN_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    fos_state_e         st;
    logic [SECTORS-1:0] sel_mask;
    logic               erase_begun;
    logic [NCTR-1:0]    ctr_clr, ctr_inc;
    logic [CW-1:0]      cnt [NCTR];
    logic               prog_bad;
    logic               busy, selected, status_rd;
    logic               op_tog, sec_tog;
    fos_flags_t         flags;

    always_comb begin
        prog_bad  = |(~cmd_old_data & cmd_new_data);
        busy      = is_busy(st);
        selected  = sel_mask[rd_sector];
        status_rd = busy || (st == ST_SUSP && selected);
        flags.op_tog      = op_tog;
        flags.timeout     = (st == ST_FAIL);
        flags.erase_begun = erase_begun;
        flags.sec_tog     = sec_tog;
    end

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        fos_pulse_ctr #(.CW(CW)) u_ctr (
            .clk (clk),
            .rst (rst),
            .clr (ctr_clr[g]),
            .inc (ctr_inc[g]),
            .cnt (cnt[g])
        );
    end

    fos_seq #(
        .SECTORS(SECTORS), .SW(SW), .CW(CW), .LIMIT(LIMIT),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
        .WIN_CYCLES(WIN_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd         (fos_cmd_e'(cmd_op)),
        .cmd_sector  (cmd_sector),
        .prog_bad    (prog_bad),
        .pcnt        (cnt[CTR_PROG]),
        .ecnt        (cnt[CTR_ERASE]),
        .wcnt        (cnt[CTR_WIN]),
        .st          (st),
        .sel_mask    (sel_mask),
        .erase_begun (erase_begun),
        .ctr_clr     (ctr_clr),
        .ctr_inc     (ctr_inc)
    );

    fos_toggles u_tog (
        .clk       (clk),
        .rst       (rst),
        .rd_strobe (rd_strobe),
        .status_rd (status_rd),
        .busy      (busy),
        .selected  (selected),
        .op_tog    (op_tog),
        .sec_tog   (sec_tog)
    );

    fos_rdmux #(.DW(DW)) u_mux (
        .status_rd  (status_rd),
        .flags      (flags),
        .array_data (array_data),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/fos_checker.sv
module fos_checker
    import fos_pkg::*;
#(
    parameter int SECTORS = 8,
    parameter int SW      = 3,
    parameter int DW      = 8,
    parameter int CW      = 7,
    parameter int LIMIT   = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic [2:0]         cmd_op,
    input logic               rd_strobe,
    input logic [SW-1:0]      rd_sector,
    input logic [DW-1:0]      array_data,
    input logic [DW-1:0]      rd_data,
    input fos_state_e         st,
    input logic [SECTORS-1:0] sel_mask,
    input logic               erase_begun,
    input logic               op_tog,
    input logic               sec_tog,
    input logic [CW-1:0]      pcnt
);
    a_r1_idle_passes_array: assert property (@(posedge clk) disable iff (rst)
        st == ST_IDLE |-> rd_data == array_data);

    a_r2_reserved_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && st != ST_SUSP) |->
            (rd_data[7] == 1'b0 && rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));

    a_r3_optog_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(op_tog));

    a_r3_optog_flips_busy: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && is_busy(st)) |=> op_tog != $past(op_tog));

    a_r4_sectog_unselected: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !sel_mask[rd_sector]) |=> $stable(sec_tog));

    a_r6_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FAIL && !(cmd_valid && cmd_op == 3'd5)) |=> st == ST_FAIL);

    a_r6_pulse_bound: assert property (@(posedge clk) disable iff (rst)
        pcnt <= CW'(LIMIT - 1));

    a_r8_window_not_begun: assert property (@(posedge clk) disable iff (rst)
        st == ST_EWIN |-> !erase_begun);

    a_r10_idle_no_selection: assert property (@(posedge clk) disable iff (rst)
        st == ST_IDLE |-> sel_mask == '0);
endmodule

bind flash_op_status fos_checker #(
    .SECTORS(SECTORS), .SW(SW), .DW(DW), .CW(CW), .LIMIT(LIMIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .rd_strobe   (rd_strobe),
    .rd_sector   (rd_sector),
    .array_data  (array_data),
    .rd_data     (rd_data),
    .st          (st),
    .sel_mask    (sel_mask),
    .erase_begun (erase_begun),
    .op_tog      (op_tog),
    .sec_tog     (sec_tog),
    .pcnt        (cnt[CTR_PROG])
);

// File: tb/flash_op_status_bench.sv
module flash_op_status_bench;
    localparam int P = 12;
    localparam int E = 40;
    localparam int W = 10;
    localparam int L = 64;

    localparam int K_ARR  = 0;
    localparam int K_BUSY = 1;
    localparam int K_SUSP = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [2:0] cmd_sector = '0;
    logic [7:0] cmd_old = '0, cmd_new = '0;
    logic       rd_strobe = 1'b0;
    logic [2:0] rd_sector = '0;
    logic [7:0] array_data = '0;
    logic [7:0] rd_data;

    always #10 clk = ~clk;

    flash_op_status u_flash_op_status (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sector(cmd_sector), .cmd_old_data(cmd_old), .cmd_new_data(cmd_new),
        .rd_strobe(rd_strobe), .rd_sector(rd_sector), .array_data(array_data),
        .rd_data(rd_data)
    );

    typedef struct {
        logic [7:0] exp;
        string      req;
    } sb_item_t;

    sb_item_t   sb_q[$];
    int         n_checks = 0;
    int         n_fail = 0;
    int         n_reads = 0;
    logic       m_t6 = 1'b0, m_t2 = 1'b0;
    logic [7:0] m_mask = '0;

    // monitor: compare each read against the queued expectation
    always begin
        @(negedge clk);
        #5;
        if (rd_strobe) begin
            if (sb_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL scoreboard empty: actual %h expected none", rd_data);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (rd_data !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.req, rd_data, it.exp);
                end
            end
        end
    end

    task automatic do_cmd(input logic [2:0] op, input int sec,
                          input logic [7:0] od, input logic [7:0] nd);
        @(negedge clk);
        rd_strobe  = 1'b0;
        cmd_valid  = 1'b1;
        cmd_op     = op;
        cmd_sector = sec[2:0];
        cmd_old    = od;
        cmd_new    = nd;
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            rd_strobe = 1'b0;
        end
    endtask

    task automatic rd(input int sec, input int kind, input logic to,
                      input logic et, input string req);
        sb_item_t   it;
        logic [7:0] arr;
        @(negedge clk);
        cmd_valid = 1'b0;
        n_reads++;
        arr = 8'h3C ^ 8'(n_reads * 29);
        rd_strobe  = 1'b1;
        rd_sector  = sec[2:0];
        array_data = arr;
        if (kind == K_ARR) begin
            it.exp = arr;
        end else begin
            it.exp = 8'h00;
            it.exp[6] = m_t6;
            it.exp[5] = to;
            it.exp[3] = et;
            it.exp[2] = m_t2;
            if (kind == K_BUSY) m_t6 = ~m_t6;
            if (m_mask[sec]) m_t2 = ~m_t2;
        end
        it.req = req;
        sb_q.push_back(it);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state reads array
        rd(0, K_ARR, 0, 0, "R1 reset array read");
        rd(5, K_ARR, 0, 0, "R1 idle array read");

        // R5 good program: exactly P busy reads, toggles from 0 (R2, R3)
        do_cmd(3'd0, 3, 8'hFF, 8'hA5);
        for (int i = 0; i < P; i++) rd(i % 8, K_BUSY, 0, 0, "R5 R3 program busy");
        rd(3, K_ARR, 0, 0, "R5 program done");

        // R6 bad program: L busy reads with timeout 0, then timeout 1
        do_cmd(3'd0, 1, 8'h0F, 8'hF0);
        for (int i = 0; i < L; i++) rd(1, K_BUSY, 0, 0, "R6 stall before limit");
        rd(1, K_BUSY, 1, 0, "R6 timeout set");
        nop(20);
        rd(2, K_BUSY, 1, 0, "R6 timeout sticky");
        do_cmd(3'd5, 0, 8'h00, 8'h00);
        rd(2, K_ARR, 0, 0, "R7 reset to array");

        // R7 reset ignored while programming
        do_cmd(3'd0, 4, 8'hF0, 8'h30);
        for (int i = 0; i < 3; i++) rd(4, K_BUSY, 0, 0, "R7 busy before reset");
        do_cmd(3'd5, 0, 8'h00, 8'h00);
        for (int i = 0; i < 8; i++) rd(4, K_BUSY, 0, 0, "R7 reset ignored");
        rd(4, K_ARR, 0, 0, "R7 program finished");

        // R8 sector erase window with restart
        do_cmd(3'd1, 2, 8'h00, 8'h00);
        m_mask = 8'h04;
        rd(2, K_BUSY, 0, 0, "R8 R4 window selected read");
        rd(5, K_BUSY, 0, 0, "R4 window unselected read");
        do_cmd(3'd1, 5, 8'h00, 8'h00);
        m_mask = 8'h24;
        for (int i = 0; i < W; i++) begin
            int s;
            s = (i % 3 == 0) ? 2 : ((i % 3 == 1) ? 5 : 7);
            rd(s, K_BUSY, 0, 0, "R8 R4 window restarted");
        end
        rd(2, K_BUSY, 0, 1, "R8 erase begun");
        for (int i = 0; i < 4; i++) rd(7, K_BUSY, 0, 1, "R4 erase unselected");

        // R10 suspend, R11 program in suspend
        do_cmd(3'd3, 0, 8'h00, 8'h00);
        rd(2, K_SUSP, 0, 1, "R3 R4 suspend selected read");
        rd(7, K_ARR, 0, 0, "R1 suspend unselected array");
        rd(5, K_SUSP, 0, 1, "R3 suspend selected read");
        nop(5);
        rd(5, K_SUSP, 0, 1, "R10 suspend holds");
        do_cmd(3'd0, 7, 8'hFF, 8'h0F);
        for (int i = 0; i < P; i++) rd((i % 2 == 0) ? 2 : 7, K_BUSY, 0, 1, "R11 program in suspend");
        rd(7, K_ARR, 0, 0, "R11 back to suspend array");
        rd(2, K_SUSP, 0, 1, "R11 back to suspend status");
        do_cmd(3'd4, 0, 8'h00, 8'h00);
        for (int i = 0; i < E - 5; i++) rd(5, K_BUSY, 0, 1, "R10 resumed erase");
        m_mask = 8'h00;
        rd(5, K_ARR, 0, 0, "R10 erase complete");
        rd(2, K_ARR, 0, 0, "R10 selection cleared");

        // R9 chip erase
        do_cmd(3'd2, 0, 8'h00, 8'h00);
        m_mask = 8'hFF;
        for (int i = 0; i < E; i++) rd(i % 8, K_BUSY, 0, 1, "R9 chip erase");
        m_mask = 8'h00;
        rd(6, K_ARR, 0, 0, "R9 chip erase done");

        // R7 failed program during suspend returns to suspend
        do_cmd(3'd1, 1, 8'h00, 8'h00);
        m_mask = 8'h02;
        nop(W);
        nop(3);
        do_cmd(3'd3, 0, 8'h00, 8'h00);
        do_cmd(3'd0, 4, 8'h00, 8'h01);
        nop(L);
        rd(1, K_BUSY, 1, 1, "R6 timeout in suspend program");
        do_cmd(3'd5, 0, 8'h00, 8'h00);
        rd(4, K_ARR, 0, 0, "R7 reset back to suspend array");
        rd(1, K_SUSP, 0, 1, "R7 reset back to suspend status");
        do_cmd(3'd4, 0, 8'h00, 8'h00);
        nop(E - 4);
        rd(1, K_BUSY, 0, 1, "R10 last erase cycle");
        m_mask = 8'h00;
        rd(1, K_ARR, 0, 0, "R10 erase done after resume");

        nop(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule